// File: doc/BRIEF.md
# SPI Request/Response Sequencer

This block runs one complete request/response exchange through an SPI master, with no processor involved. The master is reached through its register port, and the sequencer drives that port as a bus master. A start pulse carries a 24-bit request: 16 data bits in the low half and 8 slave-select bits above them. The sequencer then runs the whole sequence by itself. It flushes the receive queue, releases the master from halt, and pushes the request with the keep-select flag set. It waits for the transmit queue to drain and polls for a reply under a fixed budget. It then pops the receive queue, lets a settling delay pass, and returns the 16-bit answer with a one-cycle done pulse.

When the poll budget runs out with no reply, the sequencer still pops the receive queue and still reports done. A separate timeout flag tells the requester that the answer came from an empty queue. Only one requester is served. A start pulse that arrives while an exchange is running is dropped.

The register port uses a simple request/acknowledge handshake. A request holds its address, direction and write data until the acknowledge arrives. Read data is sampled in the acknowledge cycle.

Top module: `spi_xfer_seq`

## Requirements
- R1: After an accepted start, the first two bus accesses are a read of the control register (offset 0x00) and then a write to it. The write carries the value just read with bit 10 (receive flush) set.
- R2: The next two accesses read the control register again and write back the value just read with bit 0 (halt) cleared. Every other bit is kept as read.
- R3: The fifth access writes the push register (offset 0x34). Its data is the 24-bit request in bits 23:0, bit 31 set to 1 to keep the selects asserted, and bits 30:24 zero.
- R4: After the push, the status register (offset 0x2C) is read repeatedly until its transmit count field (bits 15:12) reads zero. A nonzero receive count during this phase does not end the exchange.
- R5: The status register is then polled. Polling stops at the first read whose receive count field (bits 7:4) is nonzero.
- R6: At most POLL_MAX (1000) polls are made. The timeout flag is 1 at done only when all POLL_MAX polls found a zero receive count. A reply that appears on the last allowed poll gives no timeout.
- R7: Exactly one read of the pop register (offset 0x38) follows the polling phase, whether or not a reply was seen. No further bus access occurs in that exchange.
- R8: The done pulse appears SETTLE_UNITS×UNIT_CYC + 1 cycles (81 by default) after the cycle in which the pop read is acknowledged.
- R9: The answer is bits 15:0 of the popped word. Done lasts exactly one cycle. The answer and timeout flag hold their values from done until the next accepted start.
- R10: A start pulse while busy is ignored. It changes neither the request that is sent nor the bus activity after done.
- R11: A bus request keeps its address, direction and write data unchanged until it is acknowledged.
- R12: During and right after reset, busy, done, timeout and bus request are 0 and the answer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| req_i | input | 24 | Request: bits 15:0 data, bits 23:16 slave selects |
| busy_o | output | 1 | An exchange is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Poll budget ran out with no reply |
| answer_o | output | 16 | Low 16 bits of the popped word |
| bus_req_o | output | 1 | Register access request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | 8 | Register byte offset |
| bus_wdata_o | output | 32 | Write data |
| bus_ack_i | input | 1 | Access acknowledge |
| bus_rdata_i | input | 32 | Read data, valid with acknowledge |

## Verification
The bench targets the edges of the poll budget. With a reply on exactly the 1000th poll, a design with an off-by-one budget would time out or make 1001 reads. With no reply at all, a design that skipped the pop would never pulse done. It also feeds control values with unrelated bits set, so a read-modify-write that overwrote the register instead of merging would show in the written data. Status words during the drain phase carry a nonzero receive count, so a design that polled too early would stop before the queue drained. The bench counts exact settle cycles and pulses start mid-exchange, which would expose a misplaced done or a restarted sequence.

// File: rtl/spi_seq_pkg.sv
// Shared types and field positions for the SPI request/response sequencer.
// Assumes the master's control and status fields sit at the bit positions below.
package spi_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_FL,
        S_WR_FL,
        S_RD_HT,
        S_WR_HT,
        S_PUSH,
        S_TXW,
        S_RXP,
        S_POP,
        S_SETTLE,
        S_DONE
    } seq_state_t;

    localparam int FLUSH_BIT   = 10;
    localparam int HALT_BIT    = 0;
    localparam int KEEP_CS_BIT = 31;
    localparam int TXC_LSB     = 12;
    localparam int TXC_MSB     = 15;
    localparam int RXC_LSB     = 4;
    localparam int RXC_MSB     = 7;

endpackage

// File: rtl/spi_seq_timer.sv
// Loadable down-counter with a zero flag, used for the poll budget and the
// settle delay. Assumes load takes priority over decrement; stops at zero.
module spi_seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         dec_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_q;

    // Count register: load, else decrement while nonzero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (dec_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/spi_seq_bus.sv
// Builds the register-port access for each sequencer step. Purely
// combinational; assumes state, captured control value and request are stable.
module spi_seq_bus
    import spi_seq_pkg::*;
#(
    parameter int         ADDR_W   = 8,
    parameter logic [7:0] CTRL_OFS = 8'h00,
    parameter logic [7:0] STAT_OFS = 8'h2C,
    parameter logic [7:0] PUSH_OFS = 8'h34,
    parameter logic [7:0] POP_OFS  = 8'h38
) (
    input  seq_state_t        state_i,
    input  logic [31:0]       ctl_i,
    input  logic [23:0]       req_i,
    output logic              req_o,
    output logic              we_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [31:0]       wdata_o
);

    localparam logic [31:0] FLUSH_MASK = 32'(1) << FLUSH_BIT;
    localparam logic [31:0] HALT_MASK  = 32'(1) << HALT_BIT;
    localparam logic [31:0] KEEP_MASK  = 32'(1) << KEEP_CS_BIT;

    // Access decode: one register access per bus-facing state.
    always_comb begin
        req_o   = 1'b1;
        we_o    = 1'b0;
        addr_o  = ADDR_W'(CTRL_OFS);
        wdata_o = '0;
        case (state_i)
            S_RD_FL, S_RD_HT: addr_o = ADDR_W'(CTRL_OFS);
            S_WR_FL: begin
                we_o    = 1'b1;
                wdata_o = ctl_i | FLUSH_MASK;
            end
            S_WR_HT: begin
                we_o    = 1'b1;
                wdata_o = ctl_i & ~HALT_MASK;
            end
            S_PUSH: begin
                we_o    = 1'b1;
                addr_o  = ADDR_W'(PUSH_OFS);
                wdata_o = KEEP_MASK | {8'h00, req_i};
            end
            S_TXW, S_RXP: addr_o = ADDR_W'(STAT_OFS);
            S_POP:        addr_o = ADDR_W'(POP_OFS);
            default:      req_o  = 1'b0;
        endcase
    end

endmodule

// File: rtl/spi_xfer_seq.sv
// SPI request/response sequencer top. Runs flush, un-halt, push, drain,
// bounded poll, pop and settle on the master's register port, then reports.
// Assumes a req/ack register port where read data is valid with ack.
module spi_xfer_seq
    import spi_seq_pkg::*;
#(
    parameter int         POLL_MAX     = 1000,
    parameter int         SETTLE_UNITS = 10,
    parameter int         UNIT_CYC     = 8,
    parameter int         ADDR_W       = 8,
    parameter logic [7:0] CTRL_OFS     = 8'h00,
    parameter logic [7:0] STAT_OFS     = 8'h2C,
    parameter logic [7:0] PUSH_OFS     = 8'h34,
    parameter logic [7:0] POP_OFS      = 8'h38
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [23:0]       req_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              timeout_o,
    output logic [15:0]       answer_o,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [31:0]       bus_wdata_o,
    input  logic              bus_ack_i,
    input  logic [31:0]       bus_rdata_i
);

    localparam int SETTLE_CYC = SETTLE_UNITS * UNIT_CYC;
    localparam int POLL_W     = $clog2(POLL_MAX + 1);
    localparam int SET_W      = $clog2(SETTLE_CYC + 1);

    seq_state_t  state_q;
    logic [23:0] req_q;
    logic [31:0] ctl_q;
    logic [15:0] ans_q;
    logic        to_q;
    logic        acc_done;
    logic        tx_empty;
    logic        rx_has;
    logic        poll_load, poll_dec, poll_zero;
    logic        set_load, set_dec, set_zero;

    assign acc_done = bus_req_o && bus_ack_i;
    assign tx_empty = (bus_rdata_i[TXC_MSB:TXC_LSB] == '0);
    assign rx_has   = (bus_rdata_i[RXC_MSB:RXC_LSB] != '0);

    assign poll_load = (state_q == S_TXW) && acc_done && tx_empty;
    assign poll_dec  = (state_q == S_RXP) && acc_done && !rx_has;
    assign set_load  = (state_q == S_POP) && acc_done;
    assign set_dec   = (state_q == S_SETTLE);

    spi_seq_timer #(.W(POLL_W)) poll_tmr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (poll_load),
        .load_val_i (POLL_W'(POLL_MAX - 1)),
        .dec_i      (poll_dec),
        .zero_o     (poll_zero)
    );

    spi_seq_timer #(.W(SET_W)) settle_tmr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (set_load),
        .load_val_i (SET_W'(SETTLE_CYC - 1)),
        .dec_i      (set_dec),
        .zero_o     (set_zero)
    );

    spi_seq_bus #(
        .ADDR_W   (ADDR_W),
        .CTRL_OFS (CTRL_OFS),
        .STAT_OFS (STAT_OFS),
        .PUSH_OFS (PUSH_OFS),
        .POP_OFS  (POP_OFS)
    ) bus_i (
        .state_i (state_q),
        .ctl_i   (ctl_q),
        .req_i   (req_q),
        .req_o   (bus_req_o),
        .we_o    (bus_we_o),
        .addr_o  (bus_addr_o),
        .wdata_o (bus_wdata_o)
    );

    // Sequence control: steps through the exchange and captures results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            req_q   <= '0;
            ctl_q   <= '0;
            ans_q   <= '0;
            to_q    <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE: if (start_i) begin
                    req_q   <= req_i;
                    to_q    <= 1'b0;
                    state_q <= S_RD_FL;
                end
                S_RD_FL: if (acc_done) begin
                    ctl_q   <= bus_rdata_i;
                    state_q <= S_WR_FL;
                end
                S_WR_FL: if (acc_done) state_q <= S_RD_HT;
                S_RD_HT: if (acc_done) begin
                    ctl_q   <= bus_rdata_i;
                    state_q <= S_WR_HT;
                end
                S_WR_HT: if (acc_done) state_q <= S_PUSH;
                S_PUSH:  if (acc_done) state_q <= S_TXW;
                S_TXW:   if (acc_done && tx_empty) state_q <= S_RXP;
                S_RXP: if (acc_done) begin
                    if (rx_has) begin
                        state_q <= S_POP;
                    end else if (poll_zero) begin
                        to_q    <= 1'b1;
                        state_q <= S_POP;
                    end
                end
                S_POP: if (acc_done) begin
                    ans_q   <= bus_rdata_i[15:0];
                    state_q <= S_SETTLE;
                end
                S_SETTLE: if (set_zero) state_q <= S_DONE;
                S_DONE:   state_q <= S_IDLE;
                default:  state_q <= S_IDLE;
            endcase
        end
    end

    assign busy_o    = (state_q != S_IDLE);
    assign done_o    = (state_q == S_DONE);
    assign timeout_o = to_q;
    assign answer_o  = ans_q;

    // R11
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o)
            && $stable(bus_we_o) && $stable(bus_wdata_o)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    answer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(answer_o) && $stable(timeout_o)));

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(req_q));

    // R4
    tx_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_TXW && acc_done && !tx_empty) |=> (state_q == S_TXW));

    // R5
    rx_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RXP && acc_done && rx_has) |=> (state_q == S_POP && !to_q));

    // R6
    poll_more_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RXP && acc_done && !rx_has && !poll_zero) |=> (state_q == S_RXP));

    // R8
    settle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(state_q) == S_SETTLE && !bus_req_o));

endmodule

// File: tb/spi_xfer_seq_tb_top.sv
module spi_xfer_seq_tb_top;

    localparam int SETTLE_CYC = 80;
    localparam int POLL_MAX   = 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [23:0] req_i = '0;
    logic        busy_o, done_o, timeout_o;
    logic [15:0] answer_o;
    logic        bus_req_o, bus_we_o;
    logic [7:0]  bus_addr_o;
    logic [31:0] bus_wdata_o;
    logic        bus_ack_i = 1'b0;
    logic [31:0] bus_rdata_i = '0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    spi_xfer_seq dut_i (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .req_i (req_i),
        .busy_o (busy_o), .done_o (done_o), .timeout_o (timeout_o),
        .answer_o (answer_o), .bus_req_o (bus_req_o), .bus_we_o (bus_we_o),
        .bus_addr_o (bus_addr_o), .bus_wdata_o (bus_wdata_o),
        .bus_ack_i (bus_ack_i), .bus_rdata_i (bus_rdata_i)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // Behavioural model of the master's registers plus the expected sequence.
    task automatic run_txn(input logic [23:0] rq, input logic [31:0] ctl_init,
                           input int tx_n, input int k_empty,
                           input logic [31:0] pop_w, input bit poke);
        logic [31:0] ctl_m = ctl_init;
        int  step = 0;
        int  tx_left = tx_n;
        bit  rx_phase = 0;
        int  polls = 0;
        bit  popped = 0;
        int  done_at = -1;
        bit  seen_done = 0;
        int  exp_polls = (k_empty >= POLL_MAX) ? POLL_MAX : k_empty + 1;
        bit  exp_to = (k_empty >= POLL_MAX);
        @(negedge clk);
        req_i   = rq;
        start_i = 1'b1;
        for (int n = 0; n < 5000 && !seen_done; n++) begin
            @(negedge clk);
            start_i = (poke && n == 2) ? 1'b1 : 1'b0;
            if (poke && n == 2) req_i = ~rq;
            if (bus_ack_i) begin
                bus_ack_i = 1'b0;
            end else if (bus_req_o) begin
                if (popped) chk(0, "R7", "access after pop", {24'h0, bus_addr_o}, 32'h0);
                case (step)
                    0, 2: begin
                        chk(!bus_we_o && bus_addr_o == 8'h00, step == 0 ? "R1" : "R2",
                            "control read", {23'h0, bus_we_o, bus_addr_o}, 32'h0);
                        bus_rdata_i = ctl_m;
                    end
                    1: begin
                        chk(bus_we_o && bus_addr_o == 8'h00 && bus_wdata_o == (ctl_m | 32'h400),
                            "R1", "flush write", bus_wdata_o, ctl_m | 32'h400);
                        ctl_m = bus_wdata_o;
                    end
                    3: begin
                        chk(bus_we_o && bus_addr_o == 8'h00 && bus_wdata_o == (ctl_m & ~32'h1),
                            "R2", "halt write", bus_wdata_o, ctl_m & ~32'h1);
                        ctl_m = bus_wdata_o;
                    end
                    4: chk(bus_we_o && bus_addr_o == 8'h34 && bus_wdata_o == {8'h80, rq},
                           "R3", "push write", bus_wdata_o, {8'h80, rq});
                    default: begin
                        chk(!bus_we_o, "R4", "status/pop is read", {31'h0, bus_we_o}, 32'h0);
                        if (bus_addr_o == 8'h2C && !rx_phase) begin
                            bus_rdata_i = (32'(tx_left) << 12) | 32'h30;
                            if (tx_left == 0) rx_phase = 1;
                            else tx_left--;
                        end else if (bus_addr_o == 8'h2C) begin
                            polls++;
                            bus_rdata_i = (polls > k_empty) ? 32'hFFFF_0F2F : 32'hFFFF_0F0F;
                            if (polls > exp_polls)
                                chk(0, "R5", "extra poll", polls, exp_polls);
                        end else if (bus_addr_o == 8'h38) begin
                            chk(rx_phase && polls == exp_polls, "R6", "polls before pop",
                                polls, exp_polls);
                            popped  = 1;
                            done_at = n + SETTLE_CYC + 1;
                            bus_rdata_i = pop_w;
                        end else begin
                            chk(0, "R4", "unexpected address", {24'h0, bus_addr_o}, 32'h2C);
                        end
                    end
                endcase
                bus_ack_i = 1'b1;
                step++;
            end
            if (done_o !== (n == done_at))
                chk(0, "R8", "done timing", {31'h0, done_o}, {31'h0, n == done_at});
            if (done_o) seen_done = 1;
        end
        start_i = 1'b0;
        chk(seen_done, "R8", "done seen", {31'h0, seen_done}, 32'h1);
        chk(popped, "R7", "pop read made", {31'h0, popped}, 32'h1);
        chk(answer_o == pop_w[15:0], "R9", "answer", {16'h0, answer_o}, {16'h0, pop_w[15:0]});
        chk(timeout_o == exp_to, "R6", "timeout flag", {31'h0, timeout_o}, {31'h0, exp_to});
    endtask

    // Idle window: no bus traffic, no done, held answer and timeout.
    task automatic idle_check(input int nc, input string rq);
        logic [15:0] ans0 = answer_o;
        logic        to0  = timeout_o;
        bit          ok   = 1;
        for (int i = 0; i < nc; i++) begin
            @(negedge clk);
            if (bus_req_o || done_o || busy_o || answer_o != ans0 || timeout_o != to0) ok = 0;
        end
        chk(ok, rq, "idle quiet and held", {15'h0, bus_req_o, answer_o}, {16'h0, ans0});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !timeout_o && !bus_req_o && answer_o == 16'h0,
            "R12", "reset outputs", {12'h0, busy_o, done_o, timeout_o, bus_req_o, answer_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !bus_req_o && !done_o, "R12", "after reset",
            {29'h0, busy_o, bus_req_o, done_o}, 32'h0);
        // Typical exchange with drain and short wait
        run_txn(24'h5A_1234, 32'h8000_0001, 2, 3, 32'hDEAD_BEEF, 0);
        idle_check(12, "R9");
        // Immediate reply, empty transmit queue
        run_txn(24'h01_00FF, 32'h0000_0400, 0, 0, 32'h1234_0001, 0);
        idle_check(5, "R9");
        // Reply on the final allowed poll
        run_txn(24'hC3_8001, 32'h7FFF_FFFF, 1, POLL_MAX - 1, 32'hAAAA_5555, 0);
        idle_check(5, "R6");
        // No reply at all: timeout yet pop and done
        run_txn(24'hFF_FFFF, 32'h0000_0000, 3, 5000, 32'h0BAD_F00D, 0);
        idle_check(5, "R7");
        // Start pulse while busy must be dropped
        run_txn(24'h12_3456, 32'h0000_0001, 1, 2, 32'h0000_CAFE, 1);
        idle_check(20, "R10");
        chk(timeout_o == 1'b0, "R10", "result of first request kept",
            {31'h0, timeout_o}, 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule